// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written over a small register bus into asynchronous serial frames on one output line. Software picks the frame shape at run time through a line-format register: a word of five to eight bits, an optional parity bit (odd, even or held at a fixed level), and one, one-and-a-half or two stop bits. A second control bit forces the line low for as long as it is set, to signal a break. Bit timing comes from a 16-bit divisor. The divisor counts reference ticks, and each bit lasts sixteen of its periods.

The divisor has no offsets of its own. When the top bit of the line-format register is set, offsets 0 and 1 reach the divisor's low and high bytes in place of the data port. A status register reports whether the holding register can take another byte and whether the whole transmitter has gone idle. Only the transmit path is built here. There is no receiver, no buffering beyond one holding register, and no interrupt logic.

Top module: `ser_tx_line`

## Requirements
- R1: After reset, txd is 1 and hold_empty and shift_empty are both 1. Offset 3 reads 0x03, offset 5 reads 0x60, and the divisor reads 0 at offsets 0 and 1 while offset 3 bit 7 is set.
- R2: A frame starts with one low bit. The data follows least significant bit first, and its length is set by offset 3 bits 1:0 (00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8). Data bits above the word length are not sent. The stop bits are high.
- R3: Offset 3 bit 3 adds one parity bit after the data. With bit 4 set, the data bits plus the parity bit hold an even number of ones. With bit 4 clear, they hold an odd number.
- R4: When bits 3 and 5 of offset 3 are both set, the parity bit is fixed: 0 when bit 4 is set and 1 when bit 4 is clear.
- R5: Offset 3 bit 2 clear gives one stop bit. Bit 2 set gives two stop bits, or one and a half stop bits when the word is 5 bits long.
- R6: While offset 3 bit 6 is set, txd is 0 from the cycle after the write. Clearing the bit restores the normal line level.
- R7: While offset 3 bit 7 is set, offsets 0 and 1 read and write the divisor's low and high bytes. A write to offset 0 in this state queues no byte.
- R8: One bit time equals divisor × 16 cycles in which ref_tick is high. Cycles with ref_tick low do not advance the timing.
- R9: A divisor of 0 freezes a frame in progress at its current line level. The frame resumes once a nonzero divisor is written.
- R10: Offset 5 bit 5 mirrors hold_empty and bit 6 mirrors shift_empty. hold_empty falls on a data write and rises when the byte moves to the shifter. shift_empty is 1 only when no frame is running and the holding register is empty.
- R11: A byte written while a frame is running goes out directly after that frame's stop bits. shift_empty stays 0 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable for the divisor |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | Transmitter fully idle |

## Verification
The hardest state to reach is a frame frozen partway through by a zero divisor. The divisor can only be changed through the remapped offsets, and changing it means rewriting the line-format register while the frame is running. The bench queues a byte with the divisor at zero and checks that the start bit holds for hundreds of cycles. It then switches to divisor access in the middle of the frame, writes a nonzero value, and waits for the frame to complete. It reaches back-to-back frames by writing a second byte at the moment the first one moves into the shifter.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_t;

   typedef struct packed {
      logic       dlab;
      logic       brk;
      logic       stick;
      logic       even;
      logic       par_en;
      logic       two_stop;
      logic [1:0] wsel;
   } lcr_t;

   localparam logic [2:0] OFF_DATA  = 3'd0;
   localparam logic [2:0] OFF_DIVHI = 3'd1;
   localparam logic [2:0] OFF_LCR   = 3'd3;
   localparam logic [2:0] OFF_STAT  = 3'd5;

   localparam logic [7:0] LCR_RESET = 8'h03;

endpackage

// File: rtl/ser_tx_regs.sv
module ser_tx_regs
   import ser_tx_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output lcr_t              lcr_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              thr_wr,
   output logic [7:0]        thr_data
);

   localparam int HI_W = DIV_W - 8;

   generate
      if (DIV_W <= 8 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must be 9..16");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
   endgenerate

   logic sel_data, sel_hi, sel_lcr;

   always_comb begin
      sel_data = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
      sel_hi   = bus_wr && (bus_addr == ADDR_W'(OFF_DIVHI));
      sel_lcr  = bus_wr && (bus_addr == ADDR_W'(OFF_LCR));
      thr_wr   = sel_data && !lcr_q.dlab;
      thr_data = bus_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lcr_q <= lcr_t'(LCR_RESET);
         div_q <= '0;
      end else begin
         if (sel_lcr) lcr_q <= lcr_t'(bus_wdata);
         if (sel_data && lcr_q.dlab) div_q[7:0] <= bus_wdata;
         if (sel_hi && lcr_q.dlab) div_q[DIV_W-1:8] <= bus_wdata[HI_W-1:0];
      end
   end

endmodule

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             os_tick
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] reload;
   logic             div_zero;

   always_comb begin
      div_zero = (div == '0);
      reload   = div_zero ? '0 : div - 1'b1;
      os_tick  = run && ref_tick && !div_zero && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (ref_tick) begin
         if (cnt_q == '0 || cnt_q >= div) cnt_q <= reload;
         else                             cnt_q <= cnt_q - 1'b1;
      end
   end

   assert_tick_needs_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |-> !os_tick);

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
   import ser_tx_pkg::*;
#(
   parameter int OS_RATE   = 16,
   parameter bit STICKY_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       thr_wr,
   input  logic [7:0] thr_data,
   input  lcr_t       lcr_q,
   output logic       txd,
   output logic       hold_empty,
   output logic       shift_empty,
   output logic       busy
);

   localparam int SUB_W = $clog2(2 * OS_RATE);
   localparam logic [SUB_W-1:0] LAST_ONE  = SUB_W'(OS_RATE - 1);
   localparam logic [SUB_W-1:0] LAST_HALF = SUB_W'(OS_RATE + OS_RATE / 2 - 1);
   localparam logic [SUB_W-1:0] LAST_TWO  = SUB_W'(2 * OS_RATE - 1);

   generate
      if (OS_RATE < 4 || (OS_RATE & (OS_RATE - 1)) != 0) begin : g_bad_os
         $error("OS_RATE must be a power of two, at least 4");
      end
   endgenerate

   tx_state_t        state_q;
   logic [7:0]       thr_q, shreg_q;
   logic             thr_full_q;
   logic [SUB_W-1:0] sub_q, stop_last_q, stop_last_d;
   logic [2:0]       bidx_q, last_idx_q;
   logic             par_en_q, pbit_q;
   logic [3:0]       nbits;
   logic [7:0]       masked;
   logic             calc_par, pbit_d, bit_end;

   always_comb begin
      nbits = 4'd5 + {2'b00, lcr_q.wsel};
      for (int i = 0; i < 8; i++) masked[i] = thr_q[i] & (4'(i) < nbits);
      calc_par = lcr_q.even ? ^masked : ~^masked;
      if (!lcr_q.two_stop)        stop_last_d = LAST_ONE;
      else if (lcr_q.wsel == 2'b00) stop_last_d = LAST_HALF;
      else                        stop_last_d = LAST_TWO;
      bit_end = os_tick && (sub_q == LAST_ONE);
   end

   generate
      if (STICKY_EN) begin : g_sticky
         assign pbit_d = lcr_q.stick ? ~lcr_q.even : calc_par;
      end else begin : g_plain
         assign pbit_d = calc_par;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         thr_q       <= '0;
         thr_full_q  <= 1'b0;
         shreg_q     <= '0;
         sub_q       <= '0;
         bidx_q      <= '0;
         last_idx_q  <= '0;
         stop_last_q <= LAST_ONE;
         par_en_q    <= 1'b0;
         pbit_q      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (thr_full_q) begin
                  shreg_q     <= masked;
                  thr_full_q  <= 1'b0;
                  last_idx_q  <= 3'(nbits - 4'd1);
                  stop_last_q <= stop_last_d;
                  par_en_q    <= lcr_q.par_en;
                  pbit_q      <= pbit_d;
                  sub_q       <= '0;
                  state_q     <= ST_START;
               end
            end
            ST_START: begin
               if (os_tick) sub_q <= bit_end ? '0 : sub_q + 1'b1;
               if (bit_end) begin
                  bidx_q  <= '0;
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (os_tick) sub_q <= bit_end ? '0 : sub_q + 1'b1;
               if (bit_end) begin
                  shreg_q <= shreg_q >> 1;
                  bidx_q  <= bidx_q + 1'b1;
                  if (bidx_q == last_idx_q) state_q <= par_en_q ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: begin
               if (os_tick) sub_q <= bit_end ? '0 : sub_q + 1'b1;
               if (bit_end) state_q <= ST_STOP;
            end
            default: begin
               if (os_tick) begin
                  if (sub_q == stop_last_q) begin
                     sub_q   <= '0;
                     state_q <= ST_IDLE;
                  end else begin
                     sub_q <= sub_q + 1'b1;
                  end
               end
            end
         endcase
         if (thr_wr) begin
            thr_q      <= thr_data;
            thr_full_q <= 1'b1;
         end
      end
   end

   logic line;
   always_comb begin
      case (state_q)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg_q[0];
         ST_PAR:   line = pbit_q;
         default:  line = 1'b1;
      endcase
      txd         = lcr_q.brk ? 1'b0 : line;
      hold_empty  = !thr_full_q;
      busy        = (state_q != ST_IDLE);
      shift_empty = !busy && !thr_full_q;
   end

   assert_bit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) |-> (bidx_q <= last_idx_q));

   assert_sub_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START || state_q == ST_DATA || state_q == ST_PAR)
         |-> (sub_q <= LAST_ONE));

   assert_stop_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP) |-> (sub_q <= stop_last_q));

endmodule

// File: rtl/ser_tx_line.sv
module ser_tx_line
   import ser_tx_pkg::*;
#(
   parameter int DIV_W     = 16,
   parameter int OS_RATE   = 16,
   parameter int ADDR_W    = 3,
   parameter bit STICKY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              txd,
   output logic              hold_empty,
   output logic              shift_empty
);

   lcr_t             lcr_q;
   logic [DIV_W-1:0] div_q;
   logic             thr_wr, os_tick, busy;
   logic [7:0]       thr_data;

   ser_tx_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .lcr_q(lcr_q), .div_q(div_q),
      .thr_wr(thr_wr), .thr_data(thr_data)
   );

   ser_tx_baud #(.DIV_W(DIV_W)) baud_i (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run(busy),
      .div(div_q), .os_tick(os_tick)
   );

   ser_tx_frame #(.OS_RATE(OS_RATE), .STICKY_EN(STICKY_EN)) frame_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .thr_wr(thr_wr),
      .thr_data(thr_data), .lcr_q(lcr_q), .txd(txd),
      .hold_empty(hold_empty), .shift_empty(shift_empty), .busy(busy)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFF_DATA):  if (lcr_q.dlab) bus_rdata = div_q[7:0];
         ADDR_W'(OFF_DIVHI): if (lcr_q.dlab) bus_rdata = 8'(div_q >> 8);
         ADDR_W'(OFF_LCR):   bus_rdata = lcr_q;
         ADDR_W'(OFF_STAT):  bus_rdata = {1'b0, shift_empty, hold_empty, 5'b0};
         default:            bus_rdata = '0;
      endcase
   end

   assert_div_zero_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && div_q == '0 && !lcr_q.brk) |=> (lcr_q.brk || $stable(txd)));

   assert_status_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> hold_empty);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |=> (lcr_q.brk || !txd));

   assert_dlab_no_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFF_DATA) && lcr_q.dlab && hold_empty)
         |=> hold_empty);

endmodule

// File: tb/ser_tx_line_tb.sv
module ser_tx_line_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b1;
   logic       ref_slow = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       txd, hold_empty, shift_empty;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   ser_tx_line dut_i (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
   );

   always @(negedge clk) ref_tick <= ref_slow ? ~ref_tick : 1'b1;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // lcr, divisor, data, expected parity bit, expected stop ticks
   localparam int NVEC = 11;
   localparam logic [39:0] VEC [NVEC] = '{
      {8'h03, 8'h01, 8'hA5, 8'h00, 8'd16},
      {8'h1B, 8'h01, 8'h07, 8'h01, 8'd16},
      {8'h0B, 8'h01, 8'h07, 8'h00, 8'd16},
      {8'h00, 8'h02, 8'hFF, 8'h00, 8'd16},
      {8'h04, 8'h01, 8'h15, 8'h00, 8'd24},
      {8'h07, 8'h01, 8'h3C, 8'h00, 8'd32},
      {8'h2B, 8'h01, 8'h00, 8'h01, 8'd16},
      {8'h3B, 8'h01, 8'hFF, 8'h00, 8'd16},
      {8'h01, 8'h01, 8'h2A, 8'h00, 8'd16},
      {8'h1A, 8'h01, 8'h7F, 8'h01, 8'd16},
      {8'h0E, 8'h01, 8'h01, 8'h00, 8'd32}
   };

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_div(input logic [7:0] lcr, input logic [15:0] dv);
      wr(3'd3, lcr | 8'h80);
      wr(3'd0, dv[7:0]);
      wr(3'd1, dv[15:8]);
      wr(3'd3, lcr);
   endtask

   task automatic wait_fall(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if (txd == 1'b0) begin ok = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   // Called at the negedge where the start bit was first seen.
   // Samples start, data, parity and the first stop bit at mid-bit.
   task automatic check_bits(input logic [7:0] lcr, input int bitc,
                             input logic [7:0] data, input logic par);
      int nb, pos, tgt;
      logic exp;
      string tag;
      nb  = 5 + lcr[1:0];
      pos = 0;
      for (int k = 0; k < nb + 2 + lcr[3]; k++) begin
         tgt = k * bitc + bitc / 2;
         repeat (tgt - pos) @(negedge clk);
         pos = tgt;
         if (k == 0) begin exp = 1'b0; tag = "R2"; end
         else if (k <= nb) begin exp = data[k-1]; tag = "R2"; end
         else if (lcr[3] && k == nb + 1) begin
            exp = par; tag = lcr[5] ? "R4" : "R3";
         end else begin exp = 1'b1; tag = "R2"; end
         check(tag, txd, exp, $sformatf("lcr=%0h data=%0h bit %0d", lcr, data, k));
      end
   endtask

   task automatic run_vec(input logic [39:0] v, input int refdiv);
      logic [7:0] lcr, dv, data, par, stp;
      int bitc, dur, exp_dur, tol;
      bit ok;
      {lcr, dv, data, par, stp} = v;
      set_div(lcr, {8'h00, dv});
      wr(3'd0, data);
      wait_fall(ok);
      check("R2", ok, 1, "start bit seen");
      bitc = 16 * dv * refdiv;
      dur = 0;
      fork
         begin
            while (shift_empty !== 1'b1 && dur < 20000) begin
               @(negedge clk);
               dur++;
            end
         end
         check_bits(lcr, bitc, data, par[0]);
      join
      exp_dur = ((1 + 5 + lcr[1:0] + lcr[3]) * 16 + stp) * dv * refdiv;
      tol = dv * refdiv + 3;
      checks++;
      if (dur < exp_dur - tol || dur > exp_dur + tol) begin
         errors++;
         $display("FAIL %s frame length lcr=%0h actual=%0d expected=%0d",
                  (refdiv > 1) ? "R8" : "R5", lcr, dur, exp_dur);
      end
   endtask

   initial begin
      logic [7:0] r;
      bit ok, leak;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", txd, 1, "txd idle");
      check("R1", hold_empty, 1, "hold_empty");
      check("R1", shift_empty, 1, "shift_empty");
      rd(3'd3, r); check("R1", r, 8'h03, "line format");
      rd(3'd5, r); check("R1", r, 8'h60, "status");
      wr(3'd3, 8'h83);
      rd(3'd0, r); check("R1", r, 0, "divisor low");
      rd(3'd1, r); check("R1", r, 0, "divisor high");

      // R7 divisor remap and no queueing
      wr(3'd0, 8'h12);
      wr(3'd1, 8'h34);
      rd(3'd0, r); check("R7", r, 8'h12, "divisor low readback");
      rd(3'd1, r); check("R7", r, 8'h34, "divisor high readback");
      repeat (100) @(negedge clk);
      check("R7", hold_empty, 1, "no byte queued");
      check("R7", txd, 1, "line stays idle");

      // Table of frames (R2 R3 R4 R5 R8)
      for (int i = 0; i < NVEC; i++) run_vec(VEC[i], 1);

      // R8 ref_tick gated at half rate
      ref_slow = 1'b1;
      run_vec({8'h03, 8'h01, 8'h5A, 8'h00, 8'd16}, 2);
      ref_slow = 1'b0;
      @(negedge clk);

      // R6 break
      wr(3'd3, 8'h43);
      check("R6", txd, 0, "break low");
      repeat (40) @(negedge clk);
      check("R6", txd, 0, "break held");
      wr(3'd3, 8'h03);
      check("R6", txd, 1, "break released");

      // R9 zero divisor stall, then resume
      set_div(8'h03, 16'h0000);
      wr(3'd0, 8'h55);
      repeat (3) @(negedge clk);
      check("R9", txd, 0, "start bit reached");
      repeat (300) @(negedge clk);
      check("R9", txd, 0, "frame frozen");
      check("R9", shift_empty, 0, "still busy");
      set_div(8'h03, 16'h0001);
      for (int i = 0; i < 400 && shift_empty !== 1'b1; i++) @(negedge clk);
      check("R9", shift_empty, 1, "frame finished after resume");

      // R10 R11 back-to-back
      wr(3'd0, 8'h81);
      wr(3'd0, 8'hC3);
      check("R10", hold_empty, 0, "second byte held");
      rd(3'd5, r); check("R10", r, 8'h00, "status busy");
      wait_fall(ok);
      check_bits(8'h03, 16, 8'h81, 1'b0);
      leak = 1'b0;
      for (int i = 0; i < 40 && txd !== 1'b0; i++) begin
         if (shift_empty) leak = 1'b1;
         @(negedge clk);
      end
      check("R11", leak, 0, "no idle gap");
      check("R11", txd, 0, "second start bit");
      check("R10", hold_empty, 1, "holding freed");
      check_bits(8'h03, 16, 8'hC3, 1'b0);
      for (int i = 0; i < 400 && shift_empty !== 1'b1; i++) @(negedge clk);
      rd(3'd5, r); check("R10", r, 8'h60, "status idle");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule